// File: doc/BRIEF.md
# Float-to-Integer Converter with Exponent Scaling

This block turns a single-precision floating-point word (sign, 8-bit biased exponent with bias 127, 23-bit fraction with a hidden leading one) into a 32-bit two's-complement integer. Two operations are available. The rounding operation (FIX) picks its direction from a mode bit. The truncating operation (TRUNC) always drops the fraction toward zero. An optional signed integer can be added to the exponent before conversion, which scales the input by a power of two.

A saturation switch selects what happens on overflow. With the switch on, the output clamps to the largest or smallest integer. With it off, the output wraps and the invalid flag is raised. Five flags go with each result: zero, underflow, negative, overflow and invalid. A request is presented together with `inValid`. The result and flags are registered one cycle later and hold until the next request.

Top module: `f2i_convert`

## Requirements
- R1: With `opTrunc`=0 and `modeFloor`=0, the finite in-range value is rounded to the nearest integer. An exact half rounds to the even integer.
- R2: With `opTrunc`=0 and `modeFloor`=1, the finite in-range value is rounded toward minus infinity.
- R3: With `opTrunc`=1, the value is truncated toward zero, whatever `modeFloor` holds.
- R4: When `useScale`=1, the signed `scaleIn` is added to the biased exponent before conversion. When `useScale`=0, `scaleIn` has no effect on any output.
- R5: `flagOver` is set for an Infinity input, or when biased exponent plus scale exceeds 157. With `satEn`=1, such a case returns 0x7FFFFFFF for a positive sign and 0x80000000 for a negative sign, and `flagInvalid` stays clear.
- R6: With `satEn`=0, an overflowing finite input returns the low 32 bits of the exact two's-complement value and sets `flagInvalid`. An Infinity input returns the clamp value of R5 and also sets `flagInvalid`.
- R7: `flagUnder` is set for a finite, normal input whose scaled magnitude is below one. Such an input yields 0 unless rounding carries: round-to-nearest gives 0 for magnitudes up to one half, and rounding toward minus infinity gives -1 (0xFFFFFFFF) for any negative one.
- R8: A NaN input (exponent field all ones, fraction nonzero) returns 0xFFFFFFFF and sets `flagInvalid`. `flagOver` and `flagUnder` stay clear.
- R9: An input whose exponent field is zero (zero or denormal) is flushed to zero. It returns 0 with `flagZero` set.
- R10: `flagNeg` equals bit 31 of the result, and `flagZero` is set exactly when the result is 0.
- R11: `outValid` is high exactly in the cycle after `inValid` was high. Result and flags change only on such a cycle and hold otherwise. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; captures the operands below |
| opTrunc | input | 1 | 1 selects TRUNC, 0 selects FIX |
| modeFloor | input | 1 | FIX rounding: 1 toward minus infinity, 0 to nearest-even |
| useScale | input | 1 | 1 adds `scaleIn` to the exponent |
| satEn | input | 1 | 1 clamps overflow, 0 wraps and flags invalid |
| fpIn | input | 32 | Floating-point operand: sign bit 31, exponent 30:23, fraction 22:0 |
| scaleIn | input | 32 | Signed exponent offset |
| outValid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Two's-complement integer result |
| flagZero | output | 1 | Result is zero |
| flagUnder | output | 1 | Nonzero magnitude below one |
| flagNeg | output | 1 | Result is negative |
| flagOver | output | 1 | Overflow or Infinity input |
| flagInvalid | output | 1 | NaN, or overflow/Infinity without saturation |

## Verification
Exponent scaling and the overflow decision fall in the same cycle. A moderate exponent can be pushed past the 157 threshold by the scale, or pulled down into the sub-one range where rounding and the underflow flag decide the result together. The bench sweeps scales from -40 to +40 across several exponents, with both signs. It judges each case against an integer model that divides the mantissa by the exact power of two and compares the remainder with one half. A further pass applies a large scale with `useScale` low, to show the offset leaves the output untouched.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef struct packed {
    logic capture;
    logic rndNear;
    logic rndFloor;
    logic scaleEn;
    logic satOn;
  } ctlStrobe_t;
endpackage

// File: rtl/f2i_ctrl.sv
module f2i_ctrl
  import f2i_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       opTrunc,
  input  logic       modeFloor,
  input  logic       useScale,
  input  logic       satEn,
  output ctlStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.capture  = inValid;
    strobe.rndNear  = !opTrunc && !modeFloor;
    strobe.rndFloor = !opTrunc && modeFloor;
    strobe.scaleEn  = useScale;
    strobe.satOn    = satEn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end
endmodule

// File: rtl/f2i_datapath.sv
module f2i_datapath
  import f2i_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter int OUT_W   = 32,
  parameter int SCALE_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctlStrobe_t               ctl,
  input  logic [EXP_W+MAN_W:0]     fpIn,
  input  logic [SCALE_W-1:0]       scaleIn,
  output logic [OUT_W-1:0]         result,
  output logic                     flagZero,
  output logic                     flagUnder,
  output logic                     flagNeg,
  output logic                     flagOver,
  output logic                     flagInvalid
);
  localparam int FW      = 1 + EXP_W + MAN_W;
  localparam int MW      = MAN_W + 1;
  localparam int EW      = SCALE_W + 2;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int ZERO_SH = BIAS + MAN_W;
  localparam int OVF_LIM = BIAS + OUT_W - 2;
  localparam int RCLAMP  = MW + 2;
  localparam int LW      = OUT_W + MW;
  localparam int SHW     = $clog2(LW + 1);
  localparam int RSW     = $clog2(RCLAMP + 1);
  localparam logic signed [EW-1:0] ZERO_S = EW'(ZERO_SH);
  localparam logic signed [EW-1:0] OVF_S  = EW'(OVF_LIM);
  localparam logic signed [EW-1:0] BIAS_S = EW'(BIAS);
  localparam logic signed [EW-1:0] LIML_S = EW'(OUT_W);
  localparam logic signed [EW-1:0] LIMR_S = EW'(RCLAMP);

  logic               sgn, isNan, isInf, isTiny;
  logic [EXP_W-1:0]   expF;
  logic [MAN_W-1:0]   fracF;
  logic [MW-1:0]      mant;
  logic signed [EW-1:0] effExp, lshS, rshS;
  logic               overRange, belowOne, leftMode;
  logic [SHW-1:0]     shL;
  logic [RSW-1:0]     shR;
  logic [LW-1:0]      wideL;
  logic [2*MW+1:0]    rext;
  logic [MW-1:0]      intPart;
  logic               guardBit, stickyBit, roundUp;
  logic [OUT_W-1:0]   mag, signedVal, clampVal, nextRes;
  logic               nextUnder, nextOver, nextInvalid;

  assign sgn    = fpIn[FW-1];
  assign expF   = fpIn[FW-2 -: EXP_W];
  assign fracF  = fpIn[MAN_W-1:0];
  assign isNan  = (&expF) && (|fracF);
  assign isInf  = (&expF) && !(|fracF);
  assign isTiny = !(|expF);
  assign mant   = {1'b1, fracF};

  always_comb begin
    effExp = $signed({{(EW-EXP_W){1'b0}}, expF});
    if (ctl.scaleEn)
      effExp = effExp + $signed({{2{scaleIn[SCALE_W-1]}}, scaleIn});
  end

  assign overRange = effExp > OVF_S;
  assign belowOne  = effExp < BIAS_S;
  assign leftMode  = effExp >= ZERO_S;
  assign lshS      = effExp - ZERO_S;
  assign rshS      = ZERO_S - effExp;

  // left path: exact integer, wrapping above the output width
  assign shL   = (lshS >= LIML_S) ? SHW'(OUT_W) : lshS[SHW-1:0];
  assign wideL = {{OUT_W{1'b0}}, mant} << shL;

  // right path: integer part with guard and sticky bits
  assign shR       = (rshS >= LIMR_S) ? RSW'(RCLAMP) : rshS[RSW-1:0];
  assign rext      = {mant, {RCLAMP{1'b0}}} >> shR;
  assign intPart   = rext[2*MW+1 -: MW];
  assign guardBit  = rext[MW+1];
  assign stickyBit = |rext[MW:0];

  always_comb begin
    roundUp = 1'b0;
    if (ctl.rndNear)       roundUp = guardBit && (stickyBit || intPart[0]);
    else if (ctl.rndFloor) roundUp = sgn && (guardBit || stickyBit);
  end

  assign mag       = leftMode ? wideL[OUT_W-1:0]
                              : OUT_W'(intPart) + OUT_W'(roundUp);
  assign signedVal = sgn ? (~mag + 1'b1) : mag;
  assign clampVal  = sgn ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};

  always_comb begin
    nextRes     = signedVal;
    nextUnder   = 1'b0;
    nextOver    = 1'b0;
    nextInvalid = 1'b0;
    if (isNan) begin
      nextRes     = '1;
      nextInvalid = 1'b1;
    end else if (isInf) begin
      nextRes     = clampVal;
      nextOver    = 1'b1;
      nextInvalid = !ctl.satOn;
    end else if (isTiny) begin
      nextRes = '0;
    end else if (overRange) begin
      nextOver    = 1'b1;
      nextInvalid = !ctl.satOn;
      if (ctl.satOn) nextRes = clampVal;
    end else begin
      nextUnder = belowOne;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result      <= '0;
      flagZero    <= 1'b0;
      flagUnder   <= 1'b0;
      flagNeg     <= 1'b0;
      flagOver    <= 1'b0;
      flagInvalid <= 1'b0;
    end else if (ctl.capture) begin
      result      <= nextRes;
      flagZero    <= (nextRes == '0);
      flagUnder   <= nextUnder;
      flagNeg     <= nextRes[OUT_W-1];
      flagOver    <= nextOver;
      flagInvalid <= nextInvalid;
    end
  end
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
  import f2i_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter int OUT_W   = 32,
  parameter int SCALE_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  input  logic                 opTrunc,
  input  logic                 modeFloor,
  input  logic                 useScale,
  input  logic                 satEn,
  input  logic [EXP_W+MAN_W:0] fpIn,
  input  logic [SCALE_W-1:0]   scaleIn,
  output logic                 outValid,
  output logic [OUT_W-1:0]     result,
  output logic                 flagZero,
  output logic                 flagUnder,
  output logic                 flagNeg,
  output logic                 flagOver,
  output logic                 flagInvalid
);
  ctlStrobe_t strobe;

  f2i_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opTrunc(opTrunc),
    .modeFloor(modeFloor), .useScale(useScale), .satEn(satEn),
    .strobe(strobe), .outValid(outValid)
  );

  f2i_datapath #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(OUT_W), .SCALE_W(SCALE_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(strobe), .fpIn(fpIn), .scaleIn(scaleIn),
    .result(result), .flagZero(flagZero), .flagUnder(flagUnder),
    .flagNeg(flagNeg), .flagOver(flagOver), .flagInvalid(flagInvalid)
  );
endmodule

// File: rtl/f2i_checker.sv
module f2i_checker #(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter int OUT_W   = 32,
  parameter int SCALE_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 inValid,
  input logic                 satEn,
  input logic [EXP_W+MAN_W:0] fpIn,
  input logic                 outValid,
  input logic [OUT_W-1:0]     result,
  input logic                 flagZero,
  input logic                 flagUnder,
  input logic                 flagOver,
  input logic                 flagInvalid
);
  logic [EXP_W-1:0] expSeen;
  logic             nanSeen;
  assign expSeen = fpIn[EXP_W+MAN_W-1 -: EXP_W];
  assign nanSeen = (&expSeen) && (|fpIn[MAN_W-1:0]);

  assert_valid_lat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (!outValid && $stable(result)));
  assert_nan_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && nanSeen) |=> ((&result) && flagInvalid && !flagOver && !flagUnder));
  assert_sat_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && flagOver && $past(satEn)) |->
      (result == {1'b0, {(OUT_W-1){1'b1}}} || result == {1'b1, {(OUT_W-1){1'b0}}}));
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && expSeen == '0) |=> (result == '0 && flagZero));
  assert_under_small_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && flagUnder) |->
      (result == '0 || result == OUT_W'(1) || result == '1));
endmodule

bind f2i_convert f2i_checker #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(OUT_W), .SCALE_W(SCALE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .satEn(satEn), .fpIn(fpIn),
  .outValid(outValid), .result(result), .flagZero(flagZero),
  .flagUnder(flagUnder), .flagOver(flagOver), .flagInvalid(flagInvalid)
);

// File: tb/sim_f2i_convert.sv
`timescale 1ns/100ps
module sim_f2i_convert;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0, opTrunc = 1'b0, modeFloor = 1'b0;
  logic        useScale = 1'b0, satEn = 1'b0;
  logic [31:0] fpIn = '0, scaleIn = '0;
  logic        outValid;
  logic [31:0] result;
  logic        flagZero, flagUnder, flagNeg, flagOver, flagInvalid;
  int          nChecks = 0, nFails = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  f2i_convert u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opTrunc(opTrunc),
    .modeFloor(modeFloor), .useScale(useScale), .satEn(satEn), .fpIn(fpIn),
    .scaleIn(scaleIn), .outValid(outValid), .result(result),
    .flagZero(flagZero), .flagUnder(flagUnder), .flagNeg(flagNeg),
    .flagOver(flagOver), .flagInvalid(flagInvalid)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent arithmetic model: mantissa divided by an exact power of two
  function automatic void model(input logic [31:0] f, input bit op, input bit mb,
      input bit sat, input bit usc, input logic [31:0] sc,
      output logic [31:0] r, output logic u, output logic v, output logic iv);
    bit s = f[31];
    int ex = int'(f[30:23]);
    longint e, sh, d;
    logic [63:0] m, den, q, rem, twice, mg;
    u = 0; v = 0; iv = 0;
    m = {40'd0, 1'b1, f[22:0]};
    if (ex == 255 && f[22:0] != 0) begin r = 32'hFFFFFFFF; iv = 1; return; end
    if (ex == 255) begin v = 1; iv = !sat; r = s ? 32'h80000000 : 32'h7FFFFFFF; return; end
    if (ex == 0) begin r = 0; return; end
    e = longint'(ex) + (usc ? longint'($signed(sc)) : 0);
    sh = e - 150;
    if (e > 157) begin
      v = 1;
      if (sat) begin r = s ? 32'h80000000 : 32'h7FFFFFFF; return; end
      iv = 1;
      mg = (sh >= 40) ? 64'd0 : (m << sh);
      r = s ? (32'd0 - mg[31:0]) : mg[31:0];
      return;
    end
    u = (e < 127);
    if (sh >= 0) mg = m << sh;
    else begin
      d = -sh;
      if (d >= 40) begin q = 0; rem = 1; twice = 2; den = 64'd1 << 40; end
      else begin den = 64'd1 << d; q = m / den; rem = m % den; twice = rem * 2; end
      if (op) mg = q;
      else if (mb) mg = q + ((s && rem != 0) ? 1 : 0);
      else mg = q + ((twice > den || (twice == den && q[0])) ? 1 : 0);
    end
    r = s ? (32'd0 - mg[31:0]) : mg[31:0];
  endfunction

  function automatic string tagOf(input logic [31:0] f, input bit op, input bit mb,
      input bit sat, input bit usc, input logic [31:0] sc);
    longint e;
    if (f[30:23] == 8'hFF) return (f[22:0] != 0) ? "R8" : (sat ? "R5" : "R6");
    if (f[30:23] == 8'h00) return "R9";
    e = longint'(f[30:23]) + (usc ? longint'($signed(sc)) : 0);
    if (e > 157) return sat ? "R5" : "R6";
    if (e < 127) return "R7";
    return op ? "R3" : (mb ? "R2" : "R1");
  endfunction

  task automatic run(input logic [31:0] f, input bit op, input bit mb, input bit sat,
      input bit usc, input logic [31:0] sc, input string tagOver);
    logic [31:0] er;
    logic eu, ev, ei;
    string tag;
    tag = (tagOver != "") ? tagOver : tagOf(f, op, mb, sat, usc, sc);
    @(negedge clk);
    fpIn = f; opTrunc = op; modeFloor = mb; satEn = sat; useScale = usc; scaleIn = sc;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    model(f, op, mb, sat, usc, sc, er, eu, ev, ei);
    check(tag, {result, outValid, flagUnder, flagOver, flagInvalid},
               {er, 1'b1, eu, ev, ei});
    check("R10", {62'd0, flagZero, flagNeg}, {62'd0, er == 0, er[31]});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [22:0] fr [8];
    fr = '{23'h000000, 23'h400000, 23'h200000, 23'h600000,
           23'h7FFFFF, 23'h000001, 23'h555555, 23'h2AAAAA};
    repeat (3) @(negedge clk);
    check("R11", {result, outValid, flagZero, flagUnder, flagNeg, flagOver, flagInvalid}, 64'd0);
    rst_n = 1'b1;

    // main sweep: rounding modes, underflow, overflow, wrap
    for (int ex = 110; ex <= 162; ex++)
      for (int k = 0; k < 8; k++)
        for (int s = 0; s < 2; s++)
          for (int md = 0; md < 4; md++)
            for (int st = 0; st < 2; st++)
              run({s[0], ex[7:0], fr[k]}, md[1], md[0], st[0], 1'b0, 32'd0, "");

    // exponent scaling: thresholds crossed by the offset (R4)
    for (int sc = -40; sc <= 40; sc++)
      foreach (fr[k])
        for (int s = 0; s < 2; s++) begin
          automatic int ex = (k % 2 == 0) ? 140 : 127;
          run({s[0], ex[7:0], fr[k]}, 1'b0, k[1], k[2], 1'b1, sc, "R4");
        end
    // offset ignored when not enabled (R4)
    run({1'b0, 8'd140, 23'h123456}, 1'b0, 1'b0, 1'b1, 1'b0, 32'd60, "R4");
    run({1'b1, 8'd130, 23'h400000}, 1'b1, 1'b0, 1'b0, 1'b0, -32'sd20, "R4");

    // special encodings
    for (int s = 0; s < 2; s++)
      for (int st = 0; st < 2; st++) begin
        run({s[0], 8'hFF, 23'h000000}, 1'b0, 1'b0, st[0], 1'b0, 32'd0, "");
        run({s[0], 8'hFF, 23'h000001}, 1'b0, 1'b0, st[0], 1'b0, 32'd0, "");
        run({s[0], 8'hFF, 23'h7FFFFF}, 1'b1, 1'b1, st[0], 1'b1, 32'd5, "");
        run({s[0], 8'h00, 23'h000000}, 1'b0, 1'b1, st[0], 1'b0, 32'd0, "");
        run({s[0], 8'h00, 23'h3FFFFF}, 1'b0, 1'b1, st[0], 1'b1, 32'd200, "");
      end
    // directed: ties to even, floor of small negatives
    run({1'b0, 8'd127, 23'h400000}, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, "R1");
    run({1'b1, 8'd125, 23'h000000}, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0, "R7");
    run({1'b1, 8'd126, 23'h000000}, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, "R7");

    // hold while idle (R11)
    begin
      logic [31:0] held;
      held = result;
      @(negedge clk);
      fpIn = 32'h4F000000; opTrunc = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R11", {result, outValid}, {held, 1'b0});
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule